// File: doc/BRIEF.md
# Two-Pipe Layer Priority Compositor

This block merges up to four picture layers into one RGB pixel stream, one pixel per clock. For every pixel each layer presents a coverage flag, a 24-bit colour and an 8-bit alpha. Per-layer attribute inputs decide whether the layer takes part, which of two pipes it feeds and what priority it holds. Composition runs in two steps. Inside each pipe, the covering layer with the largest priority is chosen outright, with no mixing. The two pipe results are then blended: pipe 0 goes over a fixed background colour, and pipe 1 goes over that result.

The alpha used for a layer is either its per-pixel alpha or an 8-bit global alpha, picked by a per-layer enable bit. A build-time option reproduces a known fault of this kind of compositor. In that mode, a translucent pixel that wins pipe 0 at priority 0 is thrown away and the background appears in its place. The output trails the input by three register stages: the select, the lower blend and the upper blend. A valid flag travels alongside the pixel.

Top module: `dual_pipe_compositor`

## Requirements
- R1: While `rst` is high and on the first clock after it, `out_valid` is 0 and `out_rgb` is 0.
- R2: `out_valid` equals `pix_valid` from exactly three rising clock edges earlier, and `out_rgb` belongs to the pixel presented with it.
- R3: Within one pipe, the covering layer with the numerically largest priority (`lay_prio` bits [2i+1:2i] for layer i) supplies that pipe's colour and alpha unchanged.
- R4: When covering layers in one pipe share the largest priority, the one with the lowest layer index wins.
- R5: A layer with `lay_en[i]`=0 or `pix_cov[i]`=0 never contributes, whatever its colour, alpha or priority.
- R6: A pipe with no covering enabled layer is fully transparent. If both pipes are empty the output is the background colour, which defaults to black (0x000000).
- R7: Each 8-bit channel is mixed as (a*top + (255-a)*bottom + 127)/255. First pipe 0 goes over the background, then pipe 1 goes over that result, with a being the winning layer's alpha. Colour packing is R in bits [23:16], G in [15:8] and B in [7:0], and layer i occupies `pix_rgb` bits [24i+23:24i].
- R8: With `lay_galpha_en[i]`=1 the layer's alpha is `lay_galpha[8i+7:8i]`. With it at 0 the alpha is `pix_alpha[8i+7:8i]`.
- R9: With `LOWEST_ALPHA_BUG`=1, a pipe-0 winner of priority 0 whose alpha is not 255 is discarded, so pipe 0 becomes transparent. A pipe-0 winner of higher priority, or an opaque one, is not affected.
- R10: `lay_pipe[i]`=0 routes layer i to pipe 0 and 1 routes it to pipe 1. Pipe 1 always lies above pipe 0, regardless of priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | Pixel inputs valid this cycle |
| lay_en | input | NUM_LAYERS | Layer enable bits |
| lay_pipe | input | NUM_LAYERS | Pipe select per layer |
| lay_prio | input | NUM_LAYERS*PRIO_W | Priority field per layer |
| lay_galpha_en | input | NUM_LAYERS | Global alpha enable per layer |
| lay_galpha | input | NUM_LAYERS*8 | Global alpha per layer |
| pix_cov | input | NUM_LAYERS | Layer covers this pixel |
| pix_alpha | input | NUM_LAYERS*8 | Per-pixel alpha per layer |
| pix_rgb | input | NUM_LAYERS*24 | Per-pixel colour per layer |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Composited colour |

## Verification
A wrong pipe winner shows at `out_rgb` three cycles after the pixel as the colour of the wrong layer, because every test layer carries a distinct colour. A corrupted alpha path shows the same way, as a blend value that differs from the rounded formula. A lost or doubled valid bit shows as `out_valid` out of step with the input pulse on the third edge. The quirk mode is told apart by a non-black background in a second instance, so a discarded pipe-0 pixel cannot be mistaken for a black blend.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int CH_W  = 8;
    localparam int RGB_W = 3 * CH_W;
    localparam int ACC_W = 2 * CH_W + 1;
    localparam logic [CH_W-1:0] ALPHA_MAX = '1;
    localparam logic [CH_W-1:0] ROUND_ADD = ALPHA_MAX >> 1;

    // Rounded alpha mix of one colour channel: top over bottom.
    function automatic logic [CH_W-1:0] mix_channel(
        input logic [CH_W-1:0] a,
        input logic [CH_W-1:0] t,
        input logic [CH_W-1:0] b
    );
        logic [ACC_W-1:0] acc;
        acc = ACC_W'(a) * ACC_W'(t)
            + ACC_W'(ALPHA_MAX - a) * ACC_W'(b)
            + ACC_W'(ROUND_ADD);
        return CH_W'(acc / ACC_W'(ALPHA_MAX));
    endfunction
endpackage

// File: rtl/cmp_pipe_pick.sv
module cmp_pipe_pick
    import cmp_pkg::*;
#(
    parameter int NUM_LAYERS       = 4,
    parameter int PRIO_W           = 2,
    parameter int PIPE_ID          = 0,
    parameter int LOWEST_ALPHA_BUG = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_LAYERS-1:0]        lay_en,
    input  logic [NUM_LAYERS-1:0]        lay_pipe,
    input  logic [NUM_LAYERS*PRIO_W-1:0] lay_prio,
    input  logic [NUM_LAYERS*CH_W-1:0]   lay_alpha,
    input  logic [NUM_LAYERS-1:0]        pix_cov,
    input  logic [NUM_LAYERS*RGB_W-1:0]  pix_rgb,
    output logic [CH_W-1:0]              alpha_q,
    output logic [RGB_W-1:0]             rgb_q
);
    localparam logic PIPE_BIT = 1'(PIPE_ID);

    logic [NUM_LAYERS-1:0] in_pipe;
    logic                  best_hit;
    logic [PRIO_W-1:0]     best_prio;
    logic [CH_W-1:0]       best_alpha;
    logic [RGB_W-1:0]      best_rgb;
    logic                  drop;
    logic                  hit_q;
    logic [PRIO_W-1:0]     prio_q;

    assign in_pipe = PIPE_BIT ? lay_pipe : ~lay_pipe;

    // Strict comparison keeps the lower index on a priority tie.
    always_comb begin
        best_hit   = 1'b0;
        best_prio  = '0;
        best_alpha = '0;
        best_rgb   = '0;
        for (int i = 0; i < NUM_LAYERS; i++) begin
            if (lay_en[i] && pix_cov[i] && in_pipe[i] &&
                (!best_hit || lay_prio[i*PRIO_W +: PRIO_W] > best_prio)) begin
                best_hit   = 1'b1;
                best_prio  = lay_prio[i*PRIO_W +: PRIO_W];
                best_alpha = lay_alpha[i*CH_W +: CH_W];
                best_rgb   = pix_rgb[i*RGB_W +: RGB_W];
            end
        end
    end

    generate
        if (LOWEST_ALPHA_BUG != 0 && PIPE_ID == 0) begin : g_quirk
            assign drop = best_hit && (best_prio == '0) && (best_alpha != ALPHA_MAX);
        end else begin : g_clean
            assign drop = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q   <= 1'b0;
            prio_q  <= '0;
            alpha_q <= '0;
            rgb_q   <= '0;
        end else begin
            hit_q   <= best_hit && !drop;
            prio_q  <= best_prio;
            alpha_q <= (best_hit && !drop) ? best_alpha : '0;
            rgb_q   <= best_rgb;
        end
    end

    assert_empty_pipe_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !(|(lay_en & pix_cov & in_pipe)) |=> (!hit_q && alpha_q == '0));

    generate
        if (LOWEST_ALPHA_BUG != 0 && PIPE_ID == 0) begin : g_quirk_chk
            assert_bottom_alpha_dropped_R9: assert property (@(posedge clk) disable iff (rst)
                hit_q |-> !(prio_q == '0 && alpha_q != ALPHA_MAX));
        end
    endgenerate
endmodule

// File: rtl/cmp_alpha_over.sv
module cmp_alpha_over
    import cmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [CH_W-1:0]  top_alpha,
    input  logic [RGB_W-1:0] top_rgb,
    input  logic [RGB_W-1:0] bot_rgb,
    output logic             out_valid,
    output logic [RGB_W-1:0] out_rgb
);
    logic [RGB_W-1:0] mixed;

    generate
        for (genvar ch = 0; ch < 3; ch++) begin : g_ch
            assign mixed[ch*CH_W +: CH_W] = mix_channel(top_alpha,
                top_rgb[ch*CH_W +: CH_W], bot_rgb[ch*CH_W +: CH_W]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= in_valid;
            out_rgb   <= mixed;
        end
    end

    assert_opaque_top_R7: assert property (@(posedge clk) disable iff (rst)
        (top_alpha == ALPHA_MAX) |=> (out_rgb == $past(top_rgb)));

    assert_clear_top_R6: assert property (@(posedge clk) disable iff (rst)
        (top_alpha == '0) |=> (out_rgb == $past(bot_rgb)));
endmodule

// File: rtl/dual_pipe_compositor.sv
module dual_pipe_compositor
    import cmp_pkg::*;
#(
    parameter int          NUM_LAYERS       = 4,
    parameter int          PRIO_W           = 2,
    parameter logic [23:0] BG_COLOR         = 24'h000000,
    parameter int          LOWEST_ALPHA_BUG = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pix_valid,
    input  logic [NUM_LAYERS-1:0]        lay_en,
    input  logic [NUM_LAYERS-1:0]        lay_pipe,
    input  logic [NUM_LAYERS*PRIO_W-1:0] lay_prio,
    input  logic [NUM_LAYERS-1:0]        lay_galpha_en,
    input  logic [NUM_LAYERS*8-1:0]      lay_galpha,
    input  logic [NUM_LAYERS-1:0]        pix_cov,
    input  logic [NUM_LAYERS*8-1:0]      pix_alpha,
    input  logic [NUM_LAYERS*24-1:0]     pix_rgb,
    output logic                         out_valid,
    output logic [23:0]                  out_rgb
);
    localparam int NUM_PIPES = 2;

    logic [NUM_LAYERS*CH_W-1:0] eff_alpha;
    logic [CH_W-1:0]            pipe_alpha [NUM_PIPES];
    logic [RGB_W-1:0]           pipe_rgb   [NUM_PIPES];
    logic                       s1_valid;
    logic                       s2_valid;
    logic [RGB_W-1:0]           s2_rgb;
    logic [CH_W-1:0]            s2_up_alpha;
    logic [RGB_W-1:0]           s2_up_rgb;

    generate
        for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_alpha
            assign eff_alpha[i*CH_W +: CH_W] = lay_galpha_en[i]
                ? lay_galpha[i*CH_W +: CH_W] : pix_alpha[i*CH_W +: CH_W];
        end
        for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
            cmp_pipe_pick #(
                .NUM_LAYERS      (NUM_LAYERS),
                .PRIO_W          (PRIO_W),
                .PIPE_ID         (p),
                .LOWEST_ALPHA_BUG(LOWEST_ALPHA_BUG)
            ) u_pick (
                .clk      (clk),
                .rst      (rst),
                .lay_en   (lay_en),
                .lay_pipe (lay_pipe),
                .lay_prio (lay_prio),
                .lay_alpha(eff_alpha),
                .pix_cov  (pix_cov),
                .pix_rgb  (pix_rgb),
                .alpha_q  (pipe_alpha[p]),
                .rgb_q    (pipe_rgb[p])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid    <= 1'b0;
            s2_up_alpha <= '0;
            s2_up_rgb   <= '0;
        end else begin
            s1_valid    <= pix_valid;
            s2_up_alpha <= pipe_alpha[1];
            s2_up_rgb   <= pipe_rgb[1];
        end
    end

    cmp_alpha_over u_lower (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s1_valid),
        .top_alpha(pipe_alpha[0]),
        .top_rgb  (pipe_rgb[0]),
        .bot_rgb  (BG_COLOR),
        .out_valid(s2_valid),
        .out_rgb  (s2_rgb)
    );

    cmp_alpha_over u_upper (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s2_valid),
        .top_alpha(s2_up_alpha),
        .top_rgb  (s2_up_rgb),
        .bot_rgb  (s2_rgb),
        .out_valid(out_valid),
        .out_rgb  (out_rgb)
    );

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(pix_valid, 3));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_rgb == '0));
endmodule

// File: tb/test_dual_pipe_compositor.sv
module test_dual_pipe_compositor;
    logic        clk = 1'b0;
    logic        rst;
    logic        pix_valid;
    logic [3:0]  lay_en, lay_pipe, lay_galpha_en, pix_cov;
    logic [7:0]  lay_prio;
    logic [31:0] lay_galpha, pix_alpha;
    logic [95:0] pix_rgb;
    logic        out_valid, q_valid;
    logic [23:0] out_rgb, q_rgb;

    int checks = 0;
    int failures = 0;

    localparam logic [23:0] QBG = 24'h203040;

    always #5 clk = ~clk;

    dual_pipe_compositor i_dual_pipe_compositor (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .lay_en(lay_en),
        .lay_pipe(lay_pipe), .lay_prio(lay_prio), .lay_galpha_en(lay_galpha_en),
        .lay_galpha(lay_galpha), .pix_cov(pix_cov), .pix_alpha(pix_alpha),
        .pix_rgb(pix_rgb), .out_valid(out_valid), .out_rgb(out_rgb)
    );

    dual_pipe_compositor #(.BG_COLOR(QBG), .LOWEST_ALPHA_BUG(1)) i_dual_pipe_compositor_quirk (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .lay_en(lay_en),
        .lay_pipe(lay_pipe), .lay_prio(lay_prio), .lay_galpha_en(lay_galpha_en),
        .lay_galpha(lay_galpha), .pix_cov(pix_cov), .pix_alpha(pix_alpha),
        .pix_rgb(pix_rgb), .out_valid(q_valid), .out_rgb(q_rgb)
    );

    // {cov, en, pipe, prio, expected rgb}; all layers opaque
    localparam int NV = 10;
    localparam logic [43:0] TBL [NV] = '{
        {4'hF, 4'hF, 4'h0, 8'hE4, 24'hAABBCC},  // R3 pipe 0 top priority
        {4'h0, 4'hF, 4'h0, 8'hE4, 24'h000000},  // R6 nothing covered
        {4'hF, 4'hF, 4'h0, 8'h00, 24'h112233},  // R4 tie to layer 0
        {4'hF, 4'h7, 4'h0, 8'hE4, 24'h778899},  // R5 layer 3 disabled
        {4'h3, 4'hF, 4'h0, 8'hE4, 24'h445566},  // R5 coverage limits
        {4'hF, 4'hF, 4'h1, 8'hE4, 24'h112233},  // R10 pipe 1 above
        {4'h1, 4'hF, 4'hE, 8'hE4, 24'h112233},  // R6 pipe 1 empty
        {4'hF, 4'hF, 4'h6, 8'h30, 24'h778899},  // R3 pick in pipe 1
        {4'hF, 4'hF, 4'hC, 8'h00, 24'h778899},  // R4 tie in pipe 1
        {4'hF, 4'h0, 4'h0, 8'hE4, 24'h000000}   // R5 all disabled
    };

    function automatic logic [23:0] mix3(input logic [7:0] a, input logic [23:0] t,
                                         input logic [23:0] b);
        logic [23:0] r;
        for (int c = 0; c < 3; c++) begin
            int v;
            v = (int'(a) * int'(t[c*8 +: 8]) + (255 - int'(a)) * int'(b[c*8 +: 8]) + 127) / 255;
            r[c*8 +: 8] = 8'(v);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%06h exp=%06h", req, got, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        pix_valid = 1'b0;
        lay_en = '0; lay_pipe = '0; lay_prio = '0; lay_galpha_en = '0;
        lay_galpha = '0; pix_cov = '0; pix_alpha = '1;
        pix_rgb = {24'hAABBCC, 24'h778899, 24'h445566, 24'h112233};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid", 24'(out_valid), 24'h0);
        check("R1 rgb", out_rgb, 24'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after", {23'h0, out_valid} | out_rgb, 24'h0);

        // Table of opaque selection cases
        pix_valid = 1'b1;
        for (int k = 0; k < NV; k++) begin
            {pix_cov, lay_en, lay_pipe, lay_prio} = TBL[k][43:24];
            settle();
            check($sformatf("R3/R4/R5/R6/R10 vec%0d", k), out_rgb, TBL[k][23:0]);
        end

        // R7: translucent pipe 1 over opaque pipe 0
        lay_en = 4'hF; pix_cov = 4'h3; lay_pipe = 4'h2; lay_prio = 8'h00;
        pix_rgb[47:24] = 24'hF01080;
        pix_alpha = 32'hFFFF_80FF;
        settle();
        check("R7 blend", out_rgb, mix3(8'h80, 24'hF01080, 24'h112233));
        check("R7 blend quirk", q_rgb, mix3(8'h80, 24'hF01080, 24'h112233));

        // R8: global alpha overrides per-pixel alpha
        pix_alpha = '1; lay_galpha = 32'h0000_4000; lay_galpha_en = 4'h2;
        settle();
        check("R8 global", out_rgb, mix3(8'h40, 24'hF01080, 24'h112233));
        lay_galpha_en = 4'h0;
        settle();
        check("R8 pixel", out_rgb, 24'hF01080);

        // R9: translucent bottom layer at priority 0
        pix_cov = 4'h1; pix_alpha = 32'hFFFF_FF80;
        settle();
        check("R7 over black", out_rgb, mix3(8'h80, 24'h112233, 24'h000000));
        check("R9 discarded", q_rgb, QBG);
        lay_prio = 8'h01;
        settle();
        check("R9 prio1 kept", q_rgb, mix3(8'h80, 24'h112233, QBG));
        lay_prio = 8'h00; pix_alpha = '1;
        settle();
        check("R9 opaque kept", q_rgb, 24'h112233);

        // R2: single valid pulse latency
        pix_valid = 1'b0;
        settle();
        pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        check("R2 t1", 24'(out_valid), 24'h0);
        @(negedge clk);
        check("R2 t2", 24'(out_valid), 24'h0);
        @(negedge clk);
        check("R2 t3", 24'(out_valid), 24'h1);
        @(negedge clk);
        check("R2 t4", 24'(out_valid), 24'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule